// File: doc/BRIEF.md
# Chainable Synchronous Up/Down Binary Counter

This block is a presettable binary counter built from identical 4-bit slices. Each slice changes state only on the rising clock edge. On each edge it either takes a parallel value, steps up or down by one, or holds. Each slice has two count-enable inputs, both active low. Only one of them, the carry-in enable, also gates the slice's terminal-count output. That output is active low, so one slice's output can drive the carry-in enable of the next slice with no extra logic.

The top level chains `STAGES` slices. The carry-in enable of slice 0 is the block's `ent_n` pin. The other enable, `enp_n`, goes to every slice. The terminal-count output of the last slice is the block's carry output. The whole chain therefore behaves as one synchronous counter of `STAGES*STAGE_W` bits, which is 8 bits by default. An asynchronous active-low reset clears the count; the reset is expected to be released in step with the clock.

Top module: `updn_cascade`

## Requirements
- R1: While `rst_n` is low, `q` is 0. `q` stays 0 until the first rising edge after `rst_n` goes high.
- R2: A rising edge with `load_n` low copies `d` into `q`. This happens for any value of `enp_n`, `ent_n` and `up_dn`, so loading wins over counting.
- R3: A rising edge with `load_n` high, `enp_n` low, `ent_n` low and `up_dn` high (1 = up) sets `q` to `q+1`. The all-ones value wraps to 0.
- R4: A rising edge with `load_n` high, `enp_n` low, `ent_n` low and `up_dn` low (0 = down) sets `q` to `q-1`. 0 wraps to all-ones.
- R5: A rising edge with `load_n` high and `enp_n` high leaves `q` unchanged.
- R6: A rising edge with `load_n` high and `ent_n` high leaves `q` unchanged.
- R7: `rco_n` is 0 exactly when `ent_n` is 0 and `q` is at the terminal value for the current direction: all ones when `up_dn` is 1, all zeros when `up_dn` is 0. `enp_n` has no effect on `rco_n`.
- R8: `rco_n` is combinational in `q`, `ent_n` and `up_dn`. A change of `up_dn` while `q` is 0 or all ones shows on `rco_n` before the next clock edge.
- R9: A count carries across slice boundaries in the same edge. Counting up from 0x0F gives 0x10, and counting down from 0x10 gives 0x0F.
- R10: Changes on `load_n`, `enp_n`, `ent_n` or `up_dn` between clock edges do not change `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_n | input | 1 | Active-low parallel load |
| enp_n | input | 1 | Active-low count enable shared by all slices |
| ent_n | input | 1 | Active-low count enable that also gates the carry |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| d | input | STAGES*STAGE_W | Parallel load value |
| q | output | STAGES*STAGE_W | Current count |
| rco_n | output | 1 | Active-low terminal-count carry of the whole chain |

## Verification
The bench targets the wrap points in both directions and the slice boundary at 0x0F/0x10. A chain whose carry-in gating is wrong would corrupt the upper slice there, or step it on every edge. It holds each enable high on its own while the other stays low. This exposes a design where `enp_n` blocks the carry or where one enable is ignored. It flips `up_dn` at 0 and at all ones with no clock edge, so a registered or direction-blind carry shows a stale `rco_n`. It also pulses the controls between edges, which a level-sensitive or latch-based counter would let through to `q`.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_LOAD = 2'd1,
    STEP_INC  = 2'd2,
    STEP_DEC  = 2'd3
  } step_e;

  // Pick the action for the next edge; load outranks counting.
  function automatic step_e pick_step(input logic load_n,
                                      input logic enp_n,
                                      input logic ent_n,
                                      input logic up_dn);
    step_e s;
    if (!load_n)               s = STEP_LOAD;
    else if (enp_n || ent_n)   s = STEP_HOLD;
    else if (up_dn)            s = STEP_INC;
    else                       s = STEP_DEC;
    return s;
  endfunction

endpackage

// File: rtl/ucnt_term_decode.sv
module ucnt_term_decode #(
  parameter int W = 4
) (
  input  logic [W-1:0] cnt,
  input  logic         ent_n,
  input  logic         up_dn,
  output logic         tc_n
);
  logic at_top;
  logic at_bottom;
  logic at_term;

  always_comb begin
    at_top    = &cnt;
    at_bottom = ~|cnt;
    at_term   = up_dn ? at_top : at_bottom;
    tc_n      = ~(at_term & ~ent_n);
  end
endmodule

// File: rtl/ucnt_slice.sv
module ucnt_slice
  import ucnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         enp_n,
  input  logic         ent_n,
  input  logic         up_dn,
  input  logic [W-1:0] din,
  output logic [W-1:0] cnt,
  output logic         tc_n
);
  localparam logic [W-1:0] ONE = W'(1);

  step_e        step;
  logic [W-1:0] cnt_nxt;
  logic         cnt_en;
  logic [W-1:0] cnt_q;

  // Next-state process
  always_comb begin
    step    = pick_step(load_n, enp_n, ent_n, up_dn);
    cnt_en  = (step != STEP_HOLD);
    unique case (step)
      STEP_LOAD: cnt_nxt = din;
      STEP_INC:  cnt_nxt = cnt_q + ONE;
      STEP_DEC:  cnt_nxt = cnt_q - ONE;
      default:   cnt_nxt = cnt_q;
    endcase
  end

  // Register process with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt = cnt_q;

  ucnt_term_decode #(.W(W)) u_term (
    .cnt   (cnt_q),
    .ent_n (ent_n),
    .up_dn (up_dn),
    .tc_n  (tc_n)
  );
endmodule

// File: rtl/updn_cascade.sv
module updn_cascade #(
  parameter int STAGES  = 2,
  parameter int STAGE_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_n,
  input  logic                        enp_n,
  input  logic                        ent_n,
  input  logic                        up_dn,
  input  logic [STAGES*STAGE_W-1:0]   d,
  output logic [STAGES*STAGE_W-1:0]   q,
  output logic                        rco_n
);
  localparam int W = STAGES * STAGE_W;

  // carry_n[i] is the carry-in enable of slice i
  logic [STAGES:0] carry_n;

  assign carry_n[0] = ent_n;

  for (genvar i = 0; i < STAGES; i++) begin : g_slice
    ucnt_slice #(.W(STAGE_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_n (load_n),
      .enp_n  (enp_n),
      .ent_n  (carry_n[i]),
      .up_dn  (up_dn),
      .din    (d[i*STAGE_W +: STAGE_W]),
      .cnt    (q[i*STAGE_W +: STAGE_W]),
      .tc_n   (carry_n[i+1])
    );
  end

  assign rco_n = carry_n[STAGES];
endmodule

// File: rtl/updn_cascade_chk.sv
module updn_cascade_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n,
  input logic         enp_n,
  input logic         ent_n,
  input logic         up_dn,
  input logic [W-1:0] d,
  input logic [W-1:0] q,
  input logic         rco_n
);
  localparam logic [W-1:0] ONE = W'(1);

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(d));

  a_r3_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !enp_n && !ent_n && up_dn) |=> q == $past(q) + ONE);

  a_r4_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !enp_n && !ent_n && !up_dn) |=> q == $past(q) - ONE);

  a_r5_enp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && enp_n) |=> $stable(q));

  a_r6_ent_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && ent_n) |=> $stable(q));

  // R7: the chained per-slice carry must equal the whole-word terminal decode
  a_r7_carry_decode: assert property (@(posedge clk) disable iff (!rst_n)
    rco_n == !(!ent_n && (up_dn ? (&q) : (q == '0))));
endmodule

bind updn_cascade updn_cascade_chk #(.W(STAGES*STAGE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load_n (load_n),
  .enp_n  (enp_n),
  .ent_n  (ent_n),
  .up_dn  (up_dn),
  .d      (d),
  .q      (q),
  .rco_n  (rco_n)
);

// File: tb/sim_updn_cascade.sv
`timescale 1ns/1ps
module sim_updn_cascade;
  localparam int STAGES = 2;
  localparam int SW     = 4;
  localparam int W      = STAGES * SW;
  localparam logic [W-1:0] ALL1 = '1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_n, enp_n, ent_n, up_dn;
  logic [W-1:0] d;
  logic [W-1:0] q;
  logic         rco_n;

  int checks   = 0;
  int failures = 0;
  logic [W-1:0] model;

  always #2.5 clk = ~clk;

  updn_cascade #(.STAGES(STAGES), .STAGE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .enp_n(enp_n),
    .ent_n(ent_n), .up_dn(up_dn), .d(d), .q(q), .rco_n(rco_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_rco(input logic [W-1:0] v);
    return !(!ent_n && (up_dn ? (v == ALL1) : (v == '0)));
  endfunction

  // One edge: model follows the requirements, then q and rco_n are compared.
  task automatic step(input string req);
    @(posedge clk);
    if (!load_n)                   model = d;
    else if (!enp_n && !ent_n)     model = up_dn ? model + 1'b1 : model - 1'b1;
    #1;
    chk({req, " q"}, q, model);
    chk("R7 rco_n", rco_n, exp_rco(model));
  endtask

  task automatic do_load(input logic [W-1:0] v);
    load_n = 1'b0; d = v;
    step("R2");
    load_n = 1'b1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; load_n = 1'b1; enp_n = 1'b0; ent_n = 1'b0; up_dn = 1'b1; d = '0;
    model = '0;
    repeat (3) @(posedge clk);
    #1 chk("R1 q in reset", q, '0);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1 q after release", q, '0);
  endtask

  task automatic t_load_priority;
    enp_n = 1'b0; ent_n = 1'b0; up_dn = 1'b1;
    do_load(8'hA5);
    enp_n = 1'b1; ent_n = 1'b1; up_dn = 1'b0;
    do_load(8'h3C);
  endtask

  task automatic t_up_wrap;
    do_load(8'hFD);
    enp_n = 1'b0; ent_n = 1'b0; up_dn = 1'b1;
    repeat (4) step("R3");
  endtask

  task automatic t_down_wrap;
    do_load(8'h02);
    enp_n = 1'b0; ent_n = 1'b0; up_dn = 1'b0;
    repeat (4) step("R4");
  endtask

  task automatic t_slice_carry;
    do_load(8'h0E);
    enp_n = 1'b0; ent_n = 1'b0; up_dn = 1'b1;
    repeat (2) step("R9 up");
    chk("R9 up crosses", q, 8'h10);
    up_dn = 1'b0;
    step("R9 down");
    chk("R9 down crosses", q, 8'h0F);
  endtask

  task automatic t_holds;
    do_load(8'h55);
    enp_n = 1'b1; ent_n = 1'b0; up_dn = 1'b1;
    repeat (2) step("R5");
    enp_n = 1'b0; ent_n = 1'b1;
    repeat (2) step("R6");
  endtask

  task automatic t_rco_live;
    do_load(ALL1);
    enp_n = 1'b1; ent_n = 1'b0; up_dn = 1'b1;
    #0.5 chk("R7 enp_n ignored", rco_n, 1'b0);
    up_dn = 1'b0;
    #0.5 chk("R8 flip at ones", rco_n, 1'b1);
    ent_n = 1'b1; up_dn = 1'b1;
    #0.5 chk("R7 ent_n gates", rco_n, 1'b1);
    do_load('0);
    ent_n = 1'b0; up_dn = 1'b1;
    #0.5 chk("R8 up at zero", rco_n, 1'b1);
    up_dn = 1'b0;
    #0.5 chk("R8 down at zero", rco_n, 1'b0);
  endtask

  task automatic t_between_edges;
    do_load(8'h77);
    enp_n = 1'b1; ent_n = 1'b1; up_dn = 1'b1; d = 8'h11;
    @(negedge clk);
    load_n = 1'b0; enp_n = 1'b0; ent_n = 1'b0; up_dn = 1'b0;
    #0.5;
    load_n = 1'b1; enp_n = 1'b1; ent_n = 1'b1; up_dn = 1'b1;
    #0.5 chk("R10 q steady", q, 8'h77);
    step("R10");
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk); #1;
    t_load_priority();
    t_up_wrap();
    t_down_wrap();
    t_slice_carry();
    t_holds();
    t_rco_live();
    t_between_edges();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule